// File: doc/BRIEF.md
# SMM Low-Memory Window Guard

This block owns one byte-wide configuration register and the access policy for a 128 KiB RAM window that starts at physical address 0x30000. Firmware first probes the register to learn whether the window can be protected. It then fills the window with handler code from ordinary context. Finally it seals the window so that only system-management-mode (SMM) accesses reach the RAM.

The register side is a plain address, byte data and write-strobe port with a combinational read path. The memory side takes the address of each access, a write flag and the SMM flag. It returns a pass/block decision and, for blocked reads, the byte to return in place of RAM data. Once sealed, the guard stays sealed until synchronous reset.

Top module: `smbase_guard`

## Requirements
- R1: After reset the register reads 0x00, and accesses inside the window pass without substitution in either context.
- R2: While the guard is not sealed, writing 0xff to offset 0x9c makes the register read 0x01 from the next cycle.
- R3: While the guard is not sealed, writing 0x02 to offset 0x9c seals it, and the register then reads 0x02.
- R4: While not sealed, non-SMM reads and writes inside the window are allowed and no read data is substituted.
- R5: Once sealed, a non-SMM read of any address from 0x30000 to 0x4FFFF inclusive is blocked (allow = 0) and substitution is flagged with data 0xff.
- R6: Once sealed, a non-SMM write inside the window is dropped: allow = 0 and no substitution flag.
- R7: An SMM access is always allowed with no substitution, sealed or not.
- R8: Once sealed, every write to the register is ignored and it keeps reading 0x02 until reset.
- R9: While not sealed, writing a value other than 0xff or 0x02 to the register leaves its read value unchanged.
- R10: Writes to any other offset have no effect on the register, and reads at any other offset return 0x00.
- R11: Accesses below 0x30000 or at 0x50000 and above always pass with no substitution, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Configuration offset for read and write |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rdata | output | 8 | Configuration read byte for cfg_addr |
| acc_addr | input | AW | Physical address of the memory access under check |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_smm | input | 1 | 1 when the access comes from SMM context |
| acc_allow | output | 1 | 1 when the access may reach RAM |
| acc_subst | output | 1 | 1 when read data must be replaced by acc_subst_data |
| acc_subst_data | output | 8 | Byte returned in place of RAM data |

## Verification
The bench probes the four window edges (0x2FFFF, 0x30000, 0x4FFFF, 0x50000) in every state; an off-by-one decode would leak or block one byte at an edge. It tries a second query and stray values after sealing, which an unsticky lock would let reopen the window. It writes the magic values to neighbouring offsets, which a decoder ignoring the offset would act on. It also mixes SMM and non-SMM reads and writes so that a guard which substitutes on writes, or blocks SMM, shows a wrong allow or substitute flag.

// File: rtl/smwin_pkg.sv
package smwin_pkg;

    localparam logic [7:0]  SMW_REG_OFFSET = 8'h9c;
    localparam logic [7:0]  SMW_CMD_QUERY  = 8'hff;
    localparam logic [7:0]  SMW_CMD_SEAL   = 8'h02;
    localparam logic [7:0]  SMW_FILL_BYTE  = 8'hff;
    localparam logic [63:0] SMW_WIN_BASE   = 64'h0000_0000_0003_0000;
    localparam logic [63:0] SMW_WIN_BYTES  = 64'h0000_0000_0002_0000;

    // Encodings double as register read values.
    typedef enum logic [7:0] {
        SMW_IDLE   = 8'h00,
        SMW_OPEN   = 8'h01,
        SMW_SEALED = 8'h02
    } smw_state_e;

    typedef struct packed {
        logic       allow;
        logic       subst;
        logic [7:0] data;
    } smw_resp_t;

    function automatic smw_state_e smw_next(input smw_state_e cur,
                                            input logic [7:0] cmd);
        smw_state_e nx;
        nx = cur;
        if (cur != SMW_SEALED) begin
            if (cmd == SMW_CMD_QUERY)     nx = SMW_OPEN;
            else if (cmd == SMW_CMD_SEAL) nx = SMW_SEALED;
        end
        return nx;
    endfunction

endpackage

// File: rtl/smwin_regfile.sv
module smwin_regfile
    import smwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    input  logic       cfg_we,
    output logic [7:0] cfg_rdata,
    output logic       sealed_o
);

    smw_state_e st_q, st_d;
    logic       hit_wr;

    assign hit_wr = cfg_we && (cfg_addr == SMW_REG_OFFSET);

    always_comb begin
        st_d = st_q;
        if (hit_wr) st_d = smw_next(st_q, cfg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SMW_IDLE;
        else     st_q <= st_d;
    end

    assign cfg_rdata = (cfg_addr == SMW_REG_OFFSET) ? st_q : 8'h00;
    assign sealed_o  = (st_q == SMW_SEALED);

    assert_query_opens_R2: assert property (@(posedge clk) disable iff (rst)
        (hit_wr && cfg_wdata == SMW_CMD_QUERY && st_q != SMW_SEALED) |=> (st_q == SMW_OPEN));

    assert_seal_R3: assert property (@(posedge clk) disable iff (rst)
        (hit_wr && cfg_wdata == SMW_CMD_SEAL) |=> (st_q == SMW_SEALED));

    assert_seal_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == SMW_SEALED) |=> (st_q == SMW_SEALED));

    assert_stray_value_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata != SMW_CMD_QUERY && cfg_wdata != SMW_CMD_SEAL) |=> $stable(st_q));

    assert_other_offset_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr != SMW_REG_OFFSET) |=> $stable(st_q));

endmodule

// File: rtl/smwin_gate.sv
module smwin_gate
    import smwin_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [63:0] WIN_BASE  = SMW_WIN_BASE,
    parameter logic [63:0] WIN_BYTES = SMW_WIN_BYTES
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          sealed_i,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_write,
    input  logic          acc_smm,
    output smw_resp_t     resp_o
);

    localparam logic [AW-1:0] WIN_LO = WIN_BASE[AW-1:0];
    localparam logic [AW-1:0] WIN_HI = WIN_LO + WIN_BYTES[AW-1:0] - 1'b1;

    logic in_win;
    logic blocked;

    assign in_win  = (acc_addr >= WIN_LO) && (acc_addr <= WIN_HI);
    assign blocked = sealed_i && in_win && !acc_smm;

    always_comb begin
        resp_o.allow = !blocked;
        resp_o.subst = blocked && !acc_write;
        resp_o.data  = SMW_FILL_BYTE;
    end

    assert_open_passes_R4: assert property (@(posedge clk) disable iff (rst)
        !sealed_i |-> (resp_o.allow && !resp_o.subst));

    assert_fill_byte_R5: assert property (@(posedge clk) disable iff (rst)
        resp_o.subst |-> (!resp_o.allow && resp_o.data == 8'hff && !acc_write));

    assert_write_dropped_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_write && !resp_o.allow) |-> !resp_o.subst);

    assert_smm_passes_R7: assert property (@(posedge clk) disable iff (rst)
        acc_smm |-> (resp_o.allow && !resp_o.subst));

endmodule

// File: rtl/smbase_guard.sv
module smbase_guard
    import smwin_pkg::*;
#(
    parameter int AW = 32
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    cfg_addr,
    input  logic [7:0]    cfg_wdata,
    input  logic          cfg_we,
    output logic [7:0]    cfg_rdata,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_write,
    input  logic          acc_smm,
    output logic          acc_allow,
    output logic          acc_subst,
    output logic [7:0]    acc_subst_data
);

    logic      sealed;
    smw_resp_t resp;

    smwin_regfile u_reg (
        .clk       (clk),
        .rst       (rst),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_we    (cfg_we),
        .cfg_rdata (cfg_rdata),
        .sealed_o  (sealed)
    );

    smwin_gate #(.AW(AW)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .sealed_i  (sealed),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .acc_smm   (acc_smm),
        .resp_o    (resp)
    );

    assign acc_allow      = resp.allow;
    assign acc_subst      = resp.subst;
    assign acc_subst_data = resp.data;

endmodule

// File: tb/smbase_guard_tb_top.sv
module smbase_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_addr = 8'h00, cfg_wdata = 8'h00;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_rdata;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_write = 1'b0, acc_smm = 1'b0;
    logic        acc_allow, acc_subst;
    logic [7:0]  acc_subst_data;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] m_reg;   // model: register read value

    always #2 clk = ~clk;

    smbase_guard #(.AW(32)) dut_i (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_smm(acc_smm), .acc_allow(acc_allow),
        .acc_subst(acc_subst), .acc_subst_data(acc_subst_data)
    );

    function automatic logic [7:0] model_next(logic [7:0] cur, logic [7:0] a, logic [7:0] d);
        if (a != 8'h9c || cur == 8'h02) return cur;
        if (d == 8'hff) return 8'h01;
        if (d == 8'h02) return 8'h02;
        return cur;
    endfunction

    function automatic logic [9:0] model_acc(logic [7:0] st, logic [31:0] a, logic w, logic s);
        logic inw, blk;
        inw = (a >= 32'h30000) && (a <= 32'h4ffff);
        blk = (st == 8'h02) && inw && !s;
        return {!blk, blk && !w, 8'hff};
    endfunction

    task automatic report(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; cfg_we = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        m_reg = 8'h00;
    endtask

    task automatic cfg_wr(logic [7:0] a, logic [7:0] d, string req);
        @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0; cfg_addr = 8'h9c;
        m_reg = model_next(m_reg, a, d);
        #1 report(req, {24'h0, cfg_rdata}, {24'h0, m_reg});
    endtask

    task automatic acc_chk(logic [31:0] a, logic w, logic s, string req);
        logic [9:0] e;
        @(negedge clk); acc_addr = a; acc_write = w; acc_smm = s;
        e = model_acc(m_reg, a, w, s);
        #1 report(req, {22'h0, acc_allow, acc_subst, acc_subst_data}, {22'h0, e});
    endtask

    task automatic edges(string req_in, string req_out);
        acc_chk(32'h2ffff, 1'b0, 1'b0, req_out);
        acc_chk(32'h30000, 1'b0, 1'b0, req_in);
        acc_chk(32'h4ffff, 1'b0, 1'b0, req_in);
        acc_chk(32'h50000, 1'b0, 1'b0, req_out);
        acc_chk(32'h30000, 1'b1, 1'b0, req_in);
        acc_chk(32'h4ffff, 1'b0, 1'b1, "R7");
        acc_chk(32'h30000, 1'b1, 1'b1, "R7");
    endtask

    initial begin
        logic [31:0] seed;
        seed = 32'd5150;
        void'($urandom(seed));
        do_reset();
        // R1 reset state
        @(negedge clk); cfg_addr = 8'h9c;
        #1 report("R1", {24'h0, cfg_rdata}, 32'h0);
        edges("R1", "R11");
        // R10 neighbours and other offset read
        cfg_wr(8'h9b, 8'hff, "R10");
        cfg_wr(8'h9d, 8'h02, "R10");
        @(negedge clk); cfg_addr = 8'h50;
        #1 report("R10", {24'h0, cfg_rdata}, 32'h0);
        cfg_wr(8'h9c, 8'h01, "R9");
        cfg_wr(8'h9c, 8'hff, "R2");
        cfg_wr(8'h9c, 8'h00, "R9");
        cfg_wr(8'h9c, 8'hff, "R2");
        edges("R4", "R11");
        cfg_wr(8'h9c, 8'h02, "R3");
        edges("R5", "R11");
        acc_chk(32'h3abcd, 1'b1, 1'b0, "R6");
        cfg_wr(8'h9c, 8'hff, "R8");
        cfg_wr(8'h9c, 8'h00, "R8");
        acc_chk(32'h41234, 1'b0, 1'b0, "R5");
        // Seal directly from reset
        do_reset();
        cfg_wr(8'h9c, 8'h02, "R3");
        acc_chk(32'h30000, 1'b0, 1'b0, "R5");
        // Random episodes
        for (int ep = 0; ep < 6; ep++) begin
            do_reset();
            for (int i = 0; i < 60; i++) begin
                logic [7:0] a, d;
                logic [31:0] pa;
                int k;
                k = $urandom_range(0, 9);
                a = (k < 7) ? 8'h9c : 8'($urandom);
                k = $urandom_range(0, 9);
                d = (k < 2) ? 8'hff : (k == 2) ? 8'h02 : (k == 3) ? 8'h01 : 8'($urandom);
                if ($urandom_range(0, 3) == 0)
                    cfg_wr(a, d, (m_reg == 8'h02) ? "R8" : "R9");
                k = $urandom_range(0, 3);
                pa = (k == 0) ? $urandom : 32'h2fff0 + 32'($urandom_range(0, 32'h20020));
                acc_chk(pa, 1'($urandom), 1'($urandom),
                        (m_reg == 8'h02) ? "R5" : "R4");
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule